// File: doc/BRIEF.md
# Six-Stage Pipeline Sequencer with Flush

This block models the control and occupancy of a six-stage, in-order instruction pipeline. Each stage holds a valid bit and an instruction tag, which is the program counter value the instruction was fetched from. The stages are, in order: fetch, decode, operand-address calculation, operand fetch, execute and write-back. Every valid entry moves forward one stage per clock. Fetch steps through sequential addresses by default, so it always assumes an unresolved conditional branch is not taken.

Branch outcomes are known only in the execute stage. When a taken branch is reported there, or when an interrupt is accepted, the four younger stages are squashed. The branch or redirect address enters fetch in the next cycle, and the instruction sitting in execute still goes on to write-back. A stall input freezes the whole pipeline. Each instruction that leaves write-back produces a one-cycle retire strobe carrying its tag.

Top module: `pipe6_seq`

## Requirements
- R1: While reset is asserted, every stage valid bit (`stage_valid_o`, bit 0 = fetch up to bit 5 = write-back) is 0 and `retire_o` is 0. The first instruction fetched after reset carries the tag `RESET_VEC`.
- R2: With no stall and no redirect, each valid entry moves up exactly one stage per clock. Fetch tags increase by one. The instruction fetched in cycle 1 after reset retires in cycle 6, and the n-th instruction retires in cycle n+5, so the ninth retires in cycle 14.
- R3: `br_taken_i` is ignored whenever the execute stage (bit 4) holds no valid instruction. Fetch then continues sequentially, with no change to occupancy or to retire tags.
- R4: A taken branch (`br_taken_i` high while bit 4 is valid) clears bits 1 to 4 on the next clock, which drops the contents of the fetch, decode, address and operand stages. The branch itself moves to write-back and retires in the following cycle.
- R5: The cycle after a redirect, the fetch stage holds the redirect address, and fetch continues sequentially from it. Over the four cycles after the redirected-from instruction retires, no instruction retires. The redirect target retires in the sixth cycle after the redirect was reported.
- R6: While `stall_i` is high and no redirect is requested, all stage contents and the fetch address hold and `retire_o` is 0.
- R7: A redirect takes priority over a stall. The pipeline advances and squashes in that cycle as if no stall were present.
- R8: `irq_i` is accepted in any cycle and acts as a redirect to `irq_vec_i`. When a taken branch occurs in the same cycle, the interrupt vector wins.
- R9: `retire_o` is high for exactly one cycle per instruction leaving write-back. `retire_tag_o` then holds that instruction's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze all stages and the fetch address |
| br_taken_i | input | 1 | Execute-stage branch resolved taken |
| br_target_i | input | TAG_W | Branch target address |
| irq_i | input | 1 | Interrupt request |
| irq_vec_i | input | TAG_W | Interrupt vector address |
| retire_o | output | 1 | Instruction leaves write-back this cycle |
| retire_tag_o | output | TAG_W | Tag of the retiring instruction |
| stage_valid_o | output | 6 | Per-stage valid bits, bit 0 fetch to bit 5 write-back |

## Verification
Several properties are checked every cycle by assertions. These are the one-stage shift of the valid bits, the squash pattern after any redirect, the arrival of the target in fetch, the freeze under stall, fetch resuming at target plus one when a redirect meets a stall, and the interrupt vector winning. End-to-end timing is shown only by the bench scenarios. This covers the cycle-6 first retirement, the ninth instruction retiring in cycle 14, the exact four-cycle retire gap after a taken branch, and the tag order after a stall.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;
  localparam int unsigned NUM_STAGES = 6;

  // stage order is behavioural: index = position in the pipe
  localparam int unsigned STG_FETCH  = 0;
  localparam int unsigned STG_DECODE = 1;
  localparam int unsigned STG_ADDR   = 2;
  localparam int unsigned STG_OPND   = 3;
  localparam int unsigned STG_EXEC   = 4;
  localparam int unsigned STG_WRITE  = 5;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BRANCH = 2'd1,
    CAUSE_IRQ    = 2'd2
  } redirect_e;
endpackage

// File: rtl/pipe6_redirect.sv
module pipe6_redirect
  import pipe6_pkg::*;
#(
  parameter int unsigned TAG_W = 16
) (
  input  logic             stall_i,
  input  logic             br_taken_i,
  input  logic             exec_valid_i,
  input  logic [TAG_W-1:0] br_target_i,
  input  logic             irq_i,
  input  logic [TAG_W-1:0] irq_vec_i,
  output logic             flush_o,
  output logic             advance_o,
  output logic [TAG_W-1:0] target_o
);
  redirect_e cause;

  always_comb begin
    cause = CAUSE_NONE;
    if (irq_i)                           cause = CAUSE_IRQ;
    else if (br_taken_i && exec_valid_i) cause = CAUSE_BRANCH;
  end

  assign flush_o   = (cause != CAUSE_NONE);
  assign target_o  = (cause == CAUSE_IRQ) ? irq_vec_i : br_target_i;
  // redirect overrides stall
  assign advance_o = !stall_i || flush_o;
endmodule

// File: rtl/pipe6_fetch.sv
module pipe6_fetch #(
  parameter int unsigned      TAG_W     = 16,
  parameter logic [TAG_W-1:0] RESET_VEC = '0,
  parameter int unsigned      PC_STEP   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             redirect_i,
  input  logic [TAG_W-1:0] target_i,
  output logic [TAG_W-1:0] pc_o,
  output logic [TAG_W-1:0] fetch_tag_o
);
  localparam logic [TAG_W-1:0] STEP_V = TAG_W'(PC_STEP);

  logic [TAG_W-1:0] pc_q;

  assign fetch_tag_o = redirect_i ? target_i : pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= RESET_VEC;
    else if (advance_i) pc_q <= fetch_tag_o + STEP_V;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pipe6_stage.sv
module pipe6_stage #(
  parameter int unsigned TAG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             kill_i,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
    end else if (advance_i) begin
      valid_o <= valid_i && !kill_i;
      tag_o   <= tag_i;
    end
  end
endmodule

// File: rtl/pipe6_seq.sv
module pipe6_seq
  import pipe6_pkg::*;
#(
  parameter int unsigned      TAG_W     = 16,
  parameter logic [TAG_W-1:0] RESET_VEC = 'h0100,
  parameter int unsigned      PC_STEP   = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stall_i,
  input  logic                  br_taken_i,
  input  logic [TAG_W-1:0]      br_target_i,
  input  logic                  irq_i,
  input  logic [TAG_W-1:0]      irq_vec_i,
  output logic                  retire_o,
  output logic [TAG_W-1:0]      retire_tag_o,
  output logic [NUM_STAGES-1:0] stage_valid_o
);
  localparam int unsigned LAST = NUM_STAGES - 1;

  logic                  flush, advance;
  logic [TAG_W-1:0]      redirect_tgt, fetch_pc, fetch_tag;
  logic [NUM_STAGES-1:0] vld;
  logic [TAG_W-1:0]      tag [NUM_STAGES];

  pipe6_redirect #(.TAG_W(TAG_W)) u_redirect (
    .stall_i     (stall_i),
    .br_taken_i  (br_taken_i),
    .exec_valid_i(vld[STG_EXEC]),
    .br_target_i (br_target_i),
    .irq_i       (irq_i),
    .irq_vec_i   (irq_vec_i),
    .flush_o     (flush),
    .advance_o   (advance),
    .target_o    (redirect_tgt)
  );

  pipe6_fetch #(.TAG_W(TAG_W), .RESET_VEC(RESET_VEC), .PC_STEP(PC_STEP)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .advance_i  (advance),
    .redirect_i (flush),
    .target_i   (redirect_tgt),
    .pc_o       (fetch_pc),
    .fetch_tag_o(fetch_tag)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic             v_in;
    logic [TAG_W-1:0] t_in;
    logic             kill;
    if (g == 0) begin : g_head
      assign v_in = 1'b1;
      assign t_in = fetch_tag;
      assign kill = 1'b0;
    end else begin : g_body
      assign v_in = vld[g-1];
      assign t_in = tag[g-1];
      // entries coming from stages younger than execute are squashed
      assign kill = flush && (g <= STG_EXEC);
    end
    pipe6_stage #(.TAG_W(TAG_W)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .advance_i(advance),
      .kill_i   (kill),
      .valid_i  (v_in),
      .tag_i    (t_in),
      .valid_o  (vld[g]),
      .tag_o    (tag[g])
    );
  end

  assign retire_o      = vld[LAST] && advance;
  assign retire_tag_o  = tag[LAST];
  assign stage_valid_o = vld;

  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && !flush) |=> (vld[LAST:1] == $past(vld[LAST-1:0])));

  assert_squash_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush && vld[STG_EXEC]) |=> (vld[STG_EXEC:STG_DECODE] == '0) && vld[STG_WRITE]);

  assert_target_in_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> vld[STG_FETCH] && (tag[STG_FETCH] == $past(redirect_tgt)));

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush) |=> $stable(vld) && $stable(fetch_pc) && !$past(retire_o));

  assert_flush_beats_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && flush) |=> (fetch_pc == $past(redirect_tgt) + TAG_W'(PC_STEP)));

  assert_irq_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> (tag[STG_FETCH] == $past(irq_vec_i)));
endmodule

// File: tb/pipe6_seq_test.sv
module pipe6_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall, br, irq;
  logic [15:0] br_tgt, ivec;
  logic        retire;
  logic [15:0] rtag;
  logic [5:0]  vld;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pipe6_seq #(.TAG_W(16), .RESET_VEC(16'h0100), .PC_STEP(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .br_taken_i(br),
    .br_target_i(br_tgt), .irq_i(irq), .irq_vec_i(ivec),
    .retire_o(retire), .retire_tag_o(rtag), .stage_valid_o(vld)
  );

  // {stall, br, irq, tgt[16], exp_retire, exp_tag[16], exp_valid[6]}
  localparam int NROW = 15;
  localparam logic [41:0] TBL [NROW] = '{
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h00},
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h01},
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h03},
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h07},
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h0F},
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h1F},
    {3'b000, 16'h0000, 1'b1, 16'h0100, 6'h3F},
    {3'b010, 16'h0200, 1'b1, 16'h0101, 6'h3F},
    {3'b000, 16'h0000, 1'b1, 16'h0102, 6'h21},
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h03},
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h07},
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h0F},
    {3'b000, 16'h0000, 1'b0, 16'h0000, 6'h1F},
    {3'b000, 16'h0000, 1'b1, 16'h0200, 6'h3F},
    {3'b000, 16'h0000, 1'b1, 16'h0201, 6'h3F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stall = 0; br = 0; irq = 0; br_tgt = '0; ivec = '0;
    repeat (2) @(negedge clk);
    #5;
    check("R1 valid in reset", 32'(vld), 32'h0);
    check("R1 retire in reset", 32'(retire), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
  endtask

  // move to the next cycle, applying inputs for it
  task automatic go(input logic s, input logic b, input logic i,
                    input logic [15:0] bt, input logic [15:0] iv);
    @(negedge clk);
    stall = s; br = b; irq = i; br_tgt = bt; ivec = iv;
    #5;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) go(0, 0, 0, 16'h0, 16'h0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2 R4 R5 R9: fill, taken branch in cycle 7, refill
    do_reset();
    for (int c = 0; c < NROW; c++) begin
      if (c != 0) @(negedge clk);
      stall = TBL[c][41]; br = TBL[c][40]; irq = TBL[c][39]; br_tgt = TBL[c][38:23];
      #5;
      check($sformatf("R2 R4 valid cycle %0d", c), 32'(vld), 32'(TBL[c][5:0]));
      check($sformatf("R5 R9 retire cycle %0d", c), 32'(retire), 32'(TBL[c][22]));
      if (TBL[c][22]) check($sformatf("R9 tag cycle %0d", c), 32'(rtag), 32'(TBL[c][21:6]));
    end

    // R2: nine sequential instructions, ninth retires in cycle 14
    do_reset();
    idle(13);
    check("R2 cycle 13 tag", 32'(rtag), 32'h0107);
    idle(1);
    check("R2 ninth retire cycle 14", 32'(retire), 32'h1);
    check("R2 ninth tag", 32'(rtag), 32'h0108);

    // R3: branch flag while execute empty is ignored
    do_reset();
    for (int k = 0; k < 4; k++) go(0, 1, 0, 16'h0777, 16'h0);
    idle(1);
    check("R3 valid cycle 5", 32'(vld), 32'h1F);
    idle(1);
    check("R3 retire cycle 6", 32'(rtag), 32'h0100);
    idle(1);
    check("R3 retire cycle 7", 32'(rtag), 32'h0101);
    idle(1);
    check("R3 retire cycle 8", 32'(rtag), 32'h0102);

    // R6: stall three cycles after the first retire
    do_reset();
    idle(6);
    check("R6 pre-stall retire", 32'(rtag), 32'h0100);
    for (int k = 0; k < 3; k++) begin
      go(1, 0, 0, 16'h0, 16'h0);
      check("R6 no retire under stall", 32'(retire), 32'h0);
      check("R6 valid held", 32'(vld), 32'h3F);
    end
    for (int k = 0; k < 3; k++) begin
      go(0, 0, 0, 16'h0, 16'h0);
      check("R6 retire after stall", 32'(retire), 32'h1);
      check("R6 tag order after stall", 32'(rtag), 32'(16'h0101 + k));
    end

    // R7: taken branch during stall still redirects
    do_reset();
    idle(6);
    go(1, 1, 0, 16'h0300, 16'h0);
    check("R7 retire despite stall", 32'(retire), 32'h1);
    check("R7 retire tag", 32'(rtag), 32'h0101);
    idle(1);
    check("R7 squash pattern", 32'(vld), 32'h21);
    check("R7 branch retires", 32'(rtag), 32'h0102);
    for (int k = 0; k < 4; k++) begin
      idle(1);
      check("R7 R5 retire gap", 32'(retire), 32'h0);
    end
    idle(1);
    check("R7 target retires", 32'(retire), 32'h1);
    check("R7 target tag", 32'(rtag), 32'h0300);

    // R8: interrupt and taken branch together, vector wins
    do_reset();
    idle(5);
    go(0, 1, 1, 16'h0500, 16'h0400);
    check("R8 retire at request", 32'(rtag), 32'h0100);
    idle(1);
    check("R8 squash pattern", 32'(vld), 32'h21);
    check("R8 exec instr retires", 32'(rtag), 32'h0101);
    for (int k = 0; k < 4; k++) begin
      idle(1);
      check("R8 retire gap", 32'(retire), 32'h0);
    end
    idle(1);
    check("R8 vector retires", 32'(rtag), 32'h0400);
    idle(1);
    check("R8 vector plus one", 32'(rtag), 32'h0401);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule